// File: doc/BRIEF.md
# Preloaded Timer and Event Counter

An up-counter peripheral with two writable registers: a control register and a preload register. The control register picks one of three counting sources. In interval timing the source is the system clock divided by a power-of-two prescaler. In edge counting it is one edge polarity of an external pin. In pulse measurement it is the prescaled clock, gated by an external pulse. When the counter is full and is told to advance again, it takes the preload value instead of wrapping to zero, keeps counting, and raises a one-cycle interrupt request. An interrupt enable input can mask that request.

Software first sets the mode, polarity and prescaler fields, and only then sets the run bit. A write to the preload register while the counter is stopped also places the value in the counter. A write while it runs only changes the value used at the next reload. The external pin passes through a two-stage synchroniser, and edges are detected after it, so edge-driven counts trail the pin by three clock cycles.

Control register layout: bits 7:6 mode (00 idle, 01 edge counting, 10 interval timing, 11 pulse measurement), bit 5 unused and reads 0, bit 4 run, bit 3 polarity, bits 2:0 prescaler exponent.

Top module: `tmr_evt_cnt`

## Requirements
- R1: After reset the control register reads 0x00, the counter reads 0x00 and `irq` is low.
- R2: A preload write (`wr_sel`=1) while the run bit (bit 4) is low loads both the preload register and the counter. The same write while running leaves the counter on its normal count path.
- R3: In mode 10 with prescaler exponent 0, the counter rises by one on every clock edge, starting with the edge after the one that writes the run bit.
- R4: The prescaler divides by 2^N, where N is control bits 2:0. The divider restarts whenever run is low, so the first count comes 2^N edges after the run write edge.
- R5: An advance from all ones loads the preload register value instead of zero, and counting carries on from that value.
- R6: Each overflow drives `irq` high for the one cycle after the reload edge if `irq_en` is high. If `irq_en` is low, `irq` stays low.
- R7: In mode 01 the counter adds one per synchronised edge of `evt_in`: rising edges when bit 3 is 0, falling edges when bit 3 is 1. The prescaler has no effect in this mode.
- R8: In mode 11 with bit 3 set to 1, counting starts on a rising edge and stops on a falling edge. With bit 3 set to 0, it starts on a falling edge and stops on a rising edge. A clean pulse of L cycles at divide-by-1 adds exactly L.
- R9: The counter holds its value while run is low or while the mode is 00, except for a preload write while stopped.
- R10: If an overflow and a preload write fall on the same edge, the counter reloads the old preload value. The new value is used at the following overflow.
- R11: A control read (`rd_sel`=0) returns the written byte with bit 5 forced to 0. A read with `rd_sel`=1 returns the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 preload |
| wr_data | input | DW | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 counter |
| rd_data | output | DW | Read data (combinational) |
| evt_in | input | 1 | External event or pulse pin, asynchronous |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-cycle overflow interrupt request |

## Verification
The overflow reload and a preload write by software can land on the same clock edge. The bench brings the counter to 0xFF in interval timing at divide-by-1 and issues a preload write timed for the overflow edge. It then reads back the old preload value together with an interrupt pulse. At the next overflow it expects the newly written value. A running preload write that does not overlap an overflow is also checked: the count must stay on its increment path.

// File: rtl/tmr_evt_cnt.sv
module tmr_evt_cnt #(
  parameter int DW    = 8,
  parameter int PSC_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          evt_in,
  input  logic          irq_en,
  output logic          irq
);
  localparam int DIV_W = (1 << PSC_W) - 1;
  localparam logic [1:0] M_IDLE = 2'b00, M_EDGE = 2'b01, M_TIME = 2'b10, M_PULSE = 2'b11;

  logic [7:0]       ctrl_q;
  logic [DW-1:0]    pre_q, cnt_q;
  logic [2:0]       sync_q;
  logic [DIV_W-1:0] div_q, psc_mask;
  logic             pw_q, irq_q;

  wire [1:0]       mode = ctrl_q[7:6];
  wire             run  = ctrl_q[4];
  wire             pol  = ctrl_q[3];
  wire [PSC_W-1:0] psc  = ctrl_q[PSC_W-1:0];

  wire wr_ctrl = wr_en && !wr_sel;
  wire wr_pre  = wr_en && wr_sel;

  assign psc_mask = DIV_W'(({{DIV_W{1'b0}}, 1'b1} << psc) - 1'b1);
  wire tick = run && ((div_q & psc_mask) == psc_mask);

  wire rise = sync_q[1] && !sync_q[2];
  wire fall = !sync_q[1] && sync_q[2];
  wire hit      = pol ? fall : rise;
  wire pw_start = pol ? rise : fall;
  wire pw_stop  = pol ? fall : rise;

  logic step;
  always_comb begin
    case (mode)
      M_EDGE:  step = run && hit;
      M_TIME:  step = tick;
      M_PULSE: step = tick && pw_q;
      default: step = 1'b0;
    endcase
  end

  wire ovf = step && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      cnt_q  <= '0;
      sync_q <= '0;
      div_q  <= '0;
      pw_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], evt_in};
      div_q  <= run ? div_q + 1'b1 : '0;
      irq_q  <= ovf && irq_en;

      if (wr_ctrl) ctrl_q <= wr_data[7:0] & 8'hDF;
      if (wr_pre)  pre_q  <= wr_data;

      if (!run || mode != M_PULSE) pw_q <= 1'b0;
      else if (pw_start)           pw_q <= 1'b1;
      else if (pw_stop)            pw_q <= 1'b0;

      if (ovf)                 cnt_q <= pre_q;
      else if (step)           cnt_q <= cnt_q + 1'b1;
      else if (wr_pre && !run) cnt_q <= wr_data;
    end
  end

  assign rd_data = rd_sel ? cnt_q : DW'(ctrl_q);
  assign irq     = irq_q;
endmodule

// File: rtl/tmr_evt_cnt_chk.sv
module tmr_evt_cnt_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_sel,
  input logic          rd_sel,
  input logic [DW-1:0] rd_data,
  input logic          irq_en,
  input logic          irq,
  input logic [7:0]    ctrl_q,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] pre_q
);
  a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctrl_q[4] || ctrl_q[7:6] == 2'b00) && !(wr_en && wr_sel)) |=> $stable(cnt_q));

  a_r5_reload_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt_q == $past(pre_q));

  a_r6_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq);

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_q[4]) && cnt_q != $past(cnt_q) && cnt_q != $past(pre_q))
      |-> cnt_q == DW'($past(cnt_q) + 1'b1));

  a_r11_bit5_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> rd_data[5] == 1'b0);
endmodule

bind tmr_evt_cnt tmr_evt_cnt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .rd_sel(rd_sel), .rd_data(rd_data), .irq_en(irq_en), .irq(irq),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .pre_q(pre_q)
);

// File: tb/tmr_evt_cnt_bench.sv
module tmr_evt_cnt_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       evt_in = 1'b0, irq_en = 1'b0;
  logic       irq;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  tmr_evt_cnt u_tmr_evt_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .evt_in(evt_in), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output int v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; irq_en = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd(0, v); chk("R1 ctrl", v, 8'h00);
    rd(1, v); chk("R1 cnt", v, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_timer();
    int v;
    do_reset();
    wr(1, 8'h20); rd(1, v); chk("R2 stopped preload loads counter", v, 8'h20);
    wr(0, 8'h90); step(5); rd(1, v); chk("R3 div1 count", v, 8'h25);
    wr(1, 8'h77); rd(1, v); chk("R2 running preload write", v, 8'h26);
    wr(0, 8'h80); step(4); rd(1, v); chk("R9 run low holds", v, 8'h27);
    wr(0, 8'h3F); rd(0, v); chk("R11 ctrl readback", v, 8'h1F);
    step(5); rd(1, v); chk("R9 idle mode holds", v, 8'h27);
  endtask

  task automatic t_prescale();
    int v;
    do_reset();
    wr(0, 8'h93); step(7); rd(1, v); chk("R4 div8 before first tick", v, 0);
    step(1); rd(1, v); chk("R4 div8 first tick", v, 1);
    step(16); rd(1, v); chk("R4 div8 third tick", v, 3);
    wr(0, 8'h00); wr(1, 8'h00);
    wr(0, 8'h97); step(127); rd(1, v); chk("R4 div128 before tick", v, 0);
    step(1); rd(1, v); chk("R4 div128 first tick", v, 1);
  endtask

  task automatic t_overflow();
    int v;
    do_reset();
    irq_en = 1'b1;
    wr(1, 8'hFE); wr(0, 8'h90);
    step(1); rd(1, v); chk("R5 at full", v, 8'hFF); chk("R6 no irq yet", irq, 0);
    wr(1, 8'h33);
    rd(1, v); chk("R10 reload uses old preload", v, 8'hFE); chk("R6 irq pulse", irq, 1);
    step(1); rd(1, v); chk("R5 counting on", v, 8'hFF); chk("R6 irq one cycle", irq, 0);
    step(1); rd(1, v); chk("R10 new preload next overflow", v, 8'h33); chk("R6 irq second", irq, 1);
    irq_en = 1'b0;
    step(204); rd(1, v); chk("R5 full again", v, 8'hFF);
    step(1); rd(1, v); chk("R5 reload masked", v, 8'h33); chk("R6 masked irq", irq, 0);
  endtask

  task automatic pulse(input int hi, input int lo);
    evt_in = 1'b1; step(hi);
    evt_in = 1'b0; step(lo);
  endtask

  task automatic t_event();
    int v;
    evt_in = 1'b0; do_reset();
    wr(0, 8'h57);
    pulse(4, 4); rd(1, v); chk("R7 one rising edge", v, 1);
    pulse(4, 4); pulse(4, 4); rd(1, v); chk("R7 three rising edges, prescaler ignored", v, 3);
    evt_in = 1'b0; do_reset();
    wr(0, 8'h5F);
    evt_in = 1'b1; step(5); rd(1, v); chk("R7 falling mode ignores rise", v, 0);
    evt_in = 1'b0; step(5); rd(1, v); chk("R7 falling edge counted", v, 1);
    pulse(4, 4); pulse(4, 4); rd(1, v); chk("R7 three falling edges", v, 3);
  endtask

  task automatic t_pulse();
    int v;
    evt_in = 1'b0; do_reset();
    wr(0, 8'hD8); step(3);
    pulse(10, 6); rd(1, v); chk("R8 high pulse width", v, 10);
    step(5); rd(1, v); chk("R8 stopped after pulse", v, 10);
    evt_in = 1'b1; do_reset(); step(4);
    wr(0, 8'hD0); step(3);
    evt_in = 1'b0; step(6); evt_in = 1'b1; step(6);
    rd(1, v); chk("R8 low pulse width", v, 6);
  endtask

  initial begin
    t_reset();
    t_timer();
    t_prescale();
    t_overflow();
    t_event();
    t_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule